// File: doc/BRIEF.md
# Flash Block Protection Controller

This controller sits in front of a word-organised flash array, which is modelled here as an internal register array. It accepts read, program and erase requests and serves them one at a time. Before serving a request it checks the protection mode of the region the address falls in. An erase clears a whole erase block to all ones, and a program can only turn ones into zeros. Each request carries the kind of master that issued it: an instruction fetch, a data load or a debugger. This lets the block tell apart code execution and inspection of the contents.

The erase granule and the protection granule differ. An erase block holds `BLOCK_WORDS` words (256 words of 32 bits gives 1 KB). Protection is set for each aligned pair of erase blocks. The protection settings arrive as a static input vector with two bits per pair. A refused request ends after one cycle with an error flag, and the array is left untouched. A refused read returns zeros.

The protocol is a single-request handshake. A request is taken while the block is idle. `busy_o` is high while a program or erase is running. `done_o` pulses for exactly one cycle when the result is ready. Requests that arrive while the block is not idle are dropped.

Top module: `flash_prot_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `busy_o`, `done_o` and `err_o` are 0 and `rdata_o` is all zeros.
- R2: A permitted read (op code 00) asserts `done_o` in the cycle after the request is accepted. In that cycle `err_o` is 0 and `rdata_o` holds the stored word.
- R3: A permitted program (op code 01) stores the old word ANDed with `req_wdata_i`. `busy_o` stays high for `PROG_CYC` cycles, and then `done_o` is high for one cycle with `err_o` 0.
- R4: A permitted erase (op code 10) sets every word of the erase block that holds the address (block index = address / `BLOCK_WORDS`) to all ones. It leaves all other blocks unchanged. `busy_o` stays high for `BLOCK_WORDS` cycles, and then `done_o` is high for one cycle.
- R5: The protection unit of an address is its pair index = block index / 2. Its mode is `prot_i[2p+1:2p]`, where 00 is open, 01 is read-only, 10 is execute-only, and 11 is handled as execute-only.
- R6: In a read-only unit, program and erase are rejected. Reads from any source are permitted.
- R7: In an execute-only unit, program and erase are rejected. A read is permitted only with source code 00 (fetch). A read with source 01 (data), 10 (debug) or 11 is refused and returns all zeros.
- R8: Op code 11 is rejected in every unit.
- R9: Any rejected request raises `done_o` in the cycle after acceptance with `err_o` 1, and it leaves the array contents unchanged.
- R10: A request presented while `busy_o` or `done_o` is high is ignored. It has no effect on the array or on the running operation.
- R11: `done_o` is never high in two consecutive cycles and never high together with `busy_o`. `err_o` and `rdata_o` hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_i | input | 2*NUM_BLOCKS/2 | Protection mode, two bits per block pair |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_op_i | input | 2 | 00 read, 01 program, 10 erase, 11 reserved |
| req_src_i | input | 2 | 00 fetch, 01 data, 10 debug, 11 other |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | WORD_W | Program data |
| busy_o | output | 1 | Program or erase in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request was rejected |
| rdata_o | output | WORD_W | Read result, zeros if refused or not a read |

## Verification
The bench builds the block with 16-bit words, 4-word erase blocks, 8 blocks and a 3-cycle program. This gives 4 protection pairs in 32 words. At this size an erase finishes in a few cycles, and each pair can be put in a different mode at the same time (open, read-only, execute-only and the reserved code). Random traffic over these settings therefore reaches every mode, op code and source mix, including erases of the last block and program-after-program AND chains. A full read-back of the array after each phase stays cheap.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  typedef enum logic [1:0] {OP_READ = 2'b00, OP_PROG = 2'b01, OP_ERASE = 2'b10, OP_RSVD = 2'b11} op_e;
  typedef enum logic [1:0] {SRC_FETCH = 2'b00, SRC_DATA = 2'b01, SRC_DEBUG = 2'b10, SRC_OTHER = 2'b11} src_e;
  typedef enum logic [1:0] {MODE_OPEN = 2'b00, MODE_RO = 2'b01, MODE_XO = 2'b10, MODE_XO2 = 2'b11} mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_ERASE, ST_FIN} state_e;
endpackage

// File: rtl/fpc_prot_check.sv
module fpc_prot_check
  import flash_prot_pkg::*;
#(
  parameter int AW          = 11,
  parameter int BLOCK_WORDS = 256,
  parameter int NUM_PAIRS   = 4
) (
  input  logic [2*NUM_PAIRS-1:0] prot_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [1:0]             op_i,
  input  logic [1:0]             src_i,
  output logic                   allow_o
);
  localparam int BLK_SH = $clog2(BLOCK_WORDS);
  localparam int PIW    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

  logic [1:0]     mode_tab [NUM_PAIRS];
  logic [PIW-1:0] pair_idx;
  logic [1:0]     mode;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_mode
    assign mode_tab[p] = prot_i[2*p +: 2];
  end

  assign pair_idx = PIW'(addr_i >> (BLK_SH + 1));
  assign mode     = mode_tab[pair_idx];

  always_comb begin
    unique case (op_i)
      OP_READ:           allow_o = (mode == MODE_OPEN) || (mode == MODE_RO) || (src_i == SRC_FETCH);
      OP_PROG, OP_ERASE: allow_o = (mode == MODE_OPEN);
      default:           allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpc_array.sv
module fpc_array #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 2048,
  parameter int AW     = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import flash_prot_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int AW          = 11,
  parameter int BLOCK_WORDS = 256,
  parameter int PROG_CYC    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic              allow_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [AW-1:0]     mem_raddr_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_waddr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int BLK_SH = $clog2(BLOCK_WORDS);
  localparam int CMAX   = (BLOCK_WORDS > PROG_CYC) ? BLOCK_WORDS : PROG_CYC;
  localparam int CW     = $clog2(CMAX) + 1;
  localparam logic [AW-1:0] BASE_MASK = ~AW'(BLOCK_WORDS - 1);

  state_e            st_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] data_q;
  logic [CW-1:0]     cnt_q;
  logic              err_q;
  logic [WORD_W-1:0] rdata_q;
  logic              accept;

  assign accept = (st_q == ST_IDLE) && req_valid_i;

  always_comb begin
    mem_raddr_o = (st_q == ST_IDLE) ? req_addr_i : addr_q;
    mem_waddr_o = addr_q;
    mem_we_o    = (st_q == ST_ERASE) || ((st_q == ST_PROG) && (cnt_q == '0));
    mem_wdata_o = (st_q == ST_ERASE) ? '1 : (mem_rdata_i & data_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr_i;
          data_q  <= req_wdata_i;
          err_q   <= !allow_i;
          rdata_q <= (allow_i && req_op_i == OP_READ) ? mem_rdata_i : '0;
          cnt_q   <= '0;
          if (!allow_i || req_op_i == OP_READ) begin
            st_q <= ST_FIN;
          end else if (req_op_i == OP_PROG) begin
            st_q  <= ST_PROG;
            cnt_q <= CW'(PROG_CYC - 1);
          end else begin
            st_q   <= ST_ERASE;
            addr_q <= req_addr_i & BASE_MASK;
          end
        end
        ST_PROG: begin
          if (cnt_q == '0) st_q <= ST_FIN;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_ERASE: begin
          addr_q <= addr_q + 1'b1;
          if (cnt_q == CW'(BLOCK_WORDS - 1)) st_q <= ST_FIN;
          else                               cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q == ST_PROG) || (st_q == ST_ERASE);
  assign done_o  = (st_q == ST_FIN);
  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  a_r11_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(accept) |-> ($stable(err_o) && $stable(rdata_o)));
  a_r7_refused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (rdata_o == '0));
  a_r4_erase_in_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ERASE && $past(st_q == ST_ERASE)) |->
      (addr_q[AW-1:BLK_SH] == $past(addr_q[AW-1:BLK_SH])));
  a_r10_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(data_q));
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl #(
  parameter int WORD_W      = 32,
  parameter int BLOCK_WORDS = 256,
  parameter int NUM_BLOCKS  = 8,
  parameter int PROG_CYC    = 8,
  localparam int DEPTH      = BLOCK_WORDS * NUM_BLOCKS,
  localparam int AW         = $clog2(DEPTH),
  localparam int NUM_PAIRS  = NUM_BLOCKS / 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2*NUM_PAIRS-1:0] prot_i,
  input  logic                   req_valid_i,
  input  logic [1:0]             req_op_i,
  input  logic [1:0]             req_src_i,
  input  logic [AW-1:0]          req_addr_i,
  input  logic [WORD_W-1:0]      req_wdata_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [WORD_W-1:0]      rdata_o
);
  logic              allow;
  logic [AW-1:0]     mem_raddr, mem_waddr;
  logic              mem_we;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;

  fpc_prot_check #(.AW(AW), .BLOCK_WORDS(BLOCK_WORDS), .NUM_PAIRS(NUM_PAIRS)) u_check (
    .prot_i (prot_i),
    .addr_i (req_addr_i),
    .op_i   (req_op_i),
    .src_i  (req_src_i),
    .allow_o(allow)
  );

  fpc_seq #(.WORD_W(WORD_W), .AW(AW), .BLOCK_WORDS(BLOCK_WORDS), .PROG_CYC(PROG_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_op_i   (req_op_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .allow_i    (allow),
    .mem_rdata_i(mem_rdata),
    .mem_raddr_o(mem_raddr),
    .mem_we_o   (mem_we),
    .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .rdata_o    (rdata_o)
  );

  fpc_array #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_array (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .raddr_i(mem_raddr),
    .rdata_o(mem_rdata)
  );

  // R9: the array is written only while an accepted program or erase runs
  a_r9_write_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> busy_o);
  // R3: a program stores only a subset of the old ones
  a_r3_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && !(mem_wdata == '1)) |-> ((mem_wdata & ~mem_rdata) == '0));
endmodule

// File: tb/flash_prot_ctrl_test.sv
module flash_prot_ctrl_test;
  localparam int WW = 16, BW = 4, NB = 8, PC = 3;
  localparam int DEPTH = BW * NB, AW = $clog2(DEPTH), NP = NB / 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [2*NP-1:0] prot = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0, req_src = '0;
  logic [AW-1:0] req_addr = '0;
  logic [WW-1:0] req_wdata = '0;
  logic busy, done, err;
  logic [WW-1:0] rdata;

  logic [WW-1:0] ref_mem [DEPTH];
  int checks = 0, errors = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  flash_prot_ctrl #(.WORD_W(WW), .BLOCK_WORDS(BW), .NUM_BLOCKS(NB), .PROG_CYC(PC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .prot_i(prot), .req_valid_i(req_valid),
    .req_op_i(req_op), .req_src_i(req_src), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata));

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic bit exp_allow(input logic [1:0] op, input int addr, input logic [1:0] src);
    logic [1:0] m;
    m = prot[2*(addr / (2*BW)) +: 2];
    case (op)
      2'b00:        return (m == 2'b00) || (m == 2'b01) || (src == 2'b00);
      2'b01, 2'b10: return m == 2'b00;
      default:      return 0;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input int addr, input logic [WW-1:0] d,
                        input logic [1:0] src, input string req);
    bit al;
    int n, lat;
    bit busy_ok;
    al = exp_allow(op, addr, src);
    lat = !al || op == 2'b00 ? 1 : (op == 2'b01 ? PC + 1 : BW + 1);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = AW'(addr); req_wdata = d; req_src = src;
    @(negedge clk);
    req_valid = 0;
    n = 1; busy_ok = 1;
    while (!done && n < 60) begin
      if (!busy) busy_ok = 0;
      @(negedge clk); n++;
    end
    chk(n == lat, req, WW'(n), WW'(lat));
    chk(busy_ok, "R11", WW'(busy_ok), 1);
    chk(err == !al, req, WW'(err), WW'(!al));
    if (op == 2'b00)
      chk(rdata == (al ? ref_mem[addr] : '0), req, rdata, al ? ref_mem[addr] : '0);
    if (al && op == 2'b01) ref_mem[addr] = ref_mem[addr] & d;
    if (al && op == 2'b10)
      for (int i = 0; i < BW; i++) ref_mem[(addr / BW) * BW + i] = '1;
    @(negedge clk);
    chk(!done, "R11", WW'(done), 0);
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < DEPTH; a++) run_op(2'b00, a, '0, 2'b00, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    // R1 reset state
    repeat (2) @(negedge clk);
    chk(!busy && !done && !err && rdata == '0, "R1", {busy, done, err}, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(!busy && !done && !err && rdata == '0, "R1", {busy, done, err}, 0);

    // R4 erase all blocks while open
    for (int b = 0; b < NB; b++) run_op(2'b10, b * BW + 1, '0, 2'b01, "R4");
    sweep("R2");
    for (int a = 0; a < DEPTH; a++) run_op(2'b00, a, '0, 2'b01, "R2");

    // R3 program ANDs
    run_op(2'b01, 5, 16'hA5F0, 2'b01, "R3");
    run_op(2'b01, 5, 16'h0FFF, 2'b10, "R3");
    run_op(2'b00, 5, '0, 2'b10, "R3");
    run_op(2'b01, 31, 16'h1234, 2'b00, "R3");
    run_op(2'b01, 6, 16'h00FF, 2'b00, "R3");
    run_op(2'b10, 7, '0, 2'b00, "R4");
    sweep("R4");

    // R5-R8 modes: pair0 RO, pair1 XO, pair2 open, pair3 reserved->XO
    run_op(2'b01, 17, 16'h5A5A, 2'b01, "R3");
    run_op(2'b01, 12, 16'h3C3C, 2'b01, "R3");
    run_op(2'b01, 29, 16'h0F0F, 2'b01, "R3");
    prot = 8'hC9;
    run_op(2'b01, 2, 16'h0000, 2'b01, "R6");
    run_op(2'b10, 4, '0, 2'b00, "R6");
    run_op(2'b00, 2, '0, 2'b01, "R6");
    run_op(2'b00, 6, '0, 2'b10, "R6");
    run_op(2'b00, 12, '0, 2'b00, "R7");
    run_op(2'b00, 12, '0, 2'b01, "R7");
    run_op(2'b00, 12, '0, 2'b10, "R7");
    run_op(2'b00, 13, '0, 2'b11, "R7");
    run_op(2'b01, 12, 16'h0000, 2'b00, "R7");
    run_op(2'b10, 9, '0, 2'b00, "R7");
    run_op(2'b00, 29, '0, 2'b10, "R5");
    run_op(2'b00, 29, '0, 2'b00, "R5");
    run_op(2'b10, 28, '0, 2'b00, "R5");
    run_op(2'b11, 20, 16'h0000, 2'b00, "R8");
    run_op(2'b11, 21, 16'h0000, 2'b01, "R8");
    // R11 result held while idle
    repeat (3) @(negedge clk);
    chk(err == 1 && rdata == '0, "R11", {err, rdata[WW-2:0]}, {1'b1, {(WW-1){1'b0}}});
    sweep("R9");

    // R10 request while busy is dropped
    @(negedge clk);
    req_valid = 1; req_op = 2'b01; req_addr = AW'(18); req_wdata = 16'h00F0; req_src = 2'b00;
    @(negedge clk);
    req_op = 2'b10; req_addr = AW'(21); req_wdata = '0;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    ref_mem[18] = ref_mem[18] & 16'h00F0;
    req_valid = 1; req_op = 2'b10; req_addr = AW'(22);
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    sweep("R10");

    // random phases
    for (int ph = 0; ph < 6; ph++) begin
      prot = (ph == 0) ? '0 : 2*NP'($urandom);
      for (int k = 0; k < 60; k++)
        run_op(2'($urandom), int'($urandom % DEPTH), WW'($urandom), 2'($urandom), "R9");
      sweep("R2");
    end
    finish_run();
  end
endmodule